// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a small synchronous static memory whose read and write cycles share a single pipeline slot. Every control input is registered on the rising clock edge. A read returns its data two enabled clocks after its address is taken. A write takes its data from the input bus two enabled clocks after its address. Because the two directions line up on the same slot, any mix of reads and writes can be issued on consecutive cycles with no idle cycle between them.

The storage is an internal register file, organised in byte lanes. Each lane is `LANE_W` bits wide, which leaves room for a parity bit, and each lane has its own active-low write strobe. Three chip-select inputs must all be at their active levels for a new access to start. A burst-advance input instead steps a two-bit counter that supplies the low address bits, in either linear or interleaved order. A clock-enable input freezes the whole block. A sleep input flushes the pipeline and keeps the data bus released. The shared data bus is split into `dq_in`, `dq_out` and an output enable, `dq_oe`.

Top module: `zt_sram`

## Requirements
- R1: After reset, `dq_oe` is low, `dq_out` is zero and every memory word reads as zero.
- R2: A new access starts only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0, with `burst_adv`=0. Any other select combination starts no access: memory is not written and `dq_oe` stays low for that slot.
- R3: When `wr_n`=1 (read) is taken at enabled edge k, `dq_oe` goes high and `dq_out` holds the word after enabled edge k+1, so it is valid at edge k+2. It stays valid until the next enabled edge.
- R4: When `wr_n`=0 (write) is taken at enabled edge k, the word on `dq_in` at enabled edge k+2 is stored. Bit i of `lane_wr_n` is active low and enables bits [i*LANE_W +: LANE_W].
- R5: Reads and writes may alternate on every cycle with no idle cycles, and each one still completes correctly.
- R6: A read whose address matches the write that completes at the same edge returns that write's data in the enabled lanes and the stored data in the other lanes.
- R7: While `clk_en`=0 the edge is ignored: no write happens, no pipeline state changes, and `dq_out` and `dq_oe` hold.
- R8: With `burst_adv`=1 the select inputs and `addr` are ignored. The access repeats the type of the last started access, at the upper address bits of that access. The low two bits are base+n mod 4 when `order_lin`=1 and base XOR n when `order_lin`=0, where n counts 1,2,3,0,... If the last cycle that was not a burst cycle was a deselect, the burst cycle does nothing.
- R9: A write cycle (starting or burst) with `lane_wr_n` all ones changes no memory bit and leaves `dq_oe` low for its slot.
- R10: `dq_oe` is never high in a cycle whose next enabled edge takes write data from `dq_in`.
- R11: `sleep`=1 forces `dq_oe` low at once. At each edge it flushes all pending accesses, so no write is performed, and it cancels the burst. `dq_oe` is still low in the first cycle after `sleep` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock enable, active high; low ignores the edge |
| sleep | input | 1 | Sleep request; flushes the pipeline and releases the bus |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | 1 = read, 0 = write on a starting cycle |
| burst_adv | input | 1 | 1 = burst cycle, next address taken from the counter |
| order_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | ADDR_W | Word address |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| dq_in | input | LANES*LANE_W | Write data from the shared bus |
| dq_out | output | LANES*LANE_W | Read data to the shared bus |
| dq_oe | output | 1 | Output enable for `dq_out` |

## Verification
The assertions check the following on every cycle:
- the select decode never starts a slot when deselected;
- a read in the first stage always raises the output enable on the next edge;
- a stalled edge leaves the pipeline and outputs unchanged;
- the burst counter steps by one;
- the bus is never driven while a write-data slot is open;
- the output enable stays low during sleep and on the cycle after it.

The data values themselves can only be shown by the bench's scenarios. These cover lane-masked writes, forwarding to an immediate read, the linear and interleaved burst orders with wrap, aborted writes, deselected cycles, and writes lost to a sleep flush. In each case the bench's reference model is compared against the output bus on every clock.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2
  } op_e;

  // low two address bits of burst step n from base
  function automatic logic [1:0] burst_lsb(input logic [1:0] base,
                                           input logic [1:0] step,
                                           input logic       lin);
    logic [1:0] r;
    if (lin) r = base + step;
    else     r = base ^ step;
    return r;
  endfunction

endpackage

// File: rtl/zt_sram_decode.sv
module zt_sram_decode
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              flush,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              wr_n,
  input  logic              burst_adv,
  input  logic              order_lin,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_wr_n,
  output op_e               cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LANES-1:0]  cmd_lanes,
  output logic              chip_sel,
  output logic [1:0]        burst_cnt
);
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q;
  logic [1:0]      base_q;
  logic [1:0]      cnt_q;
  op_e             bop_q;
  logic [1:0]      step;

  assign chip_sel  = ~sel_a_n & sel_b & ~sel_c_n;
  assign step      = cnt_q + 2'd1;
  assign burst_cnt = cnt_q;

  always_comb begin
    if (burst_adv) begin
      cmd_op   = bop_q;
      cmd_addr = {hi_q, burst_lsb(base_q, step, order_lin)};
    end else if (chip_sel) begin
      cmd_op   = wr_n ? OP_RD : OP_WR;
      cmd_addr = addr;
    end else begin
      cmd_op   = OP_NOP;
      cmd_addr = addr;
    end
    cmd_lanes = (cmd_op == OP_WR) ? ~lane_wr_n : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      bop_q  <= OP_NOP;
    end else if (flush) begin
      bop_q  <= OP_NOP;
    end else if (advance) begin
      if (burst_adv) begin
        cnt_q <= step;
      end else begin
        hi_q   <= addr[ADDR_W-1:2];
        base_q <= addr[1:0];
        cnt_q  <= 2'd0;
        bop_q  <= cmd_op;
      end
    end
  end

endmodule

// File: rtl/zt_sram_pipe.sv
module zt_sram_pipe
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              flush,
  input  op_e               in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]  in_lanes,
  output op_e               s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output op_e               s2_op,
  output logic [ADDR_W-1:0] s2_addr,
  output logic [LANES-1:0]  s2_lanes
);
  logic [LANES-1:0] s1_lanes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op    <= OP_NOP;
      s1_addr  <= '0;
      s1_lanes <= '0;
      s2_op    <= OP_NOP;
      s2_addr  <= '0;
      s2_lanes <= '0;
    end else if (flush) begin
      s1_op    <= OP_NOP;
      s1_lanes <= '0;
      s2_op    <= OP_NOP;
      s2_lanes <= '0;
    end else if (advance) begin
      s1_op    <= in_op;
      s1_addr  <= in_addr;
      s1_lanes <= in_lanes;
      s2_op    <= s1_op;
      s2_addr  <= s1_addr;
      s2_lanes <= s1_lanes;
    end
  end

endmodule

// File: rtl/zt_sram_store.sv
module zt_sram_store #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [LANE_W-1:0] lane_pick(input logic hit,
                                                  input logic [LANE_W-1:0] fresh,
                                                  input logic [LANE_W-1:0] stored);
    return hit ? fresh : stored;
  endfunction

  logic same_word;
  assign same_word = wr_en && (wr_addr == rd_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) lane_mem[i] <= '0;
      end else if (wr_en && wr_lanes[g]) begin
        lane_mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      end
    end

    // a write committing this edge is forwarded lane by lane
    assign rd_data[g*LANE_W +: LANE_W] =
      lane_pick(same_word && wr_lanes[g], wr_data[g*LANE_W +: LANE_W], lane_mem[rd_addr]);
  end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en,
  input  logic                    sleep,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    wr_n,
  input  logic                    burst_adv,
  input  logic                    order_lin,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);
  localparam int DATA_W = LANES * LANE_W;

  logic              advance;
  logic              flush;
  op_e               cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LANES-1:0]  cmd_lanes;
  logic              chip_sel;
  logic [1:0]        burst_cnt;
  op_e               s1_op;
  logic [ADDR_W-1:0] s1_addr;
  op_e               s2_op;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_lanes;
  logic              wr_en;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] dout_q;
  logic              oe_q;

  assign advance = clk_en & ~sleep;
  assign flush   = sleep;

  zt_sram_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_decode (
    .clk(clk), .rst_n(rst_n), .advance(advance), .flush(flush),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .wr_n(wr_n),
    .burst_adv(burst_adv), .order_lin(order_lin), .addr(addr),
    .lane_wr_n(lane_wr_n), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_lanes(cmd_lanes), .chip_sel(chip_sel), .burst_cnt(burst_cnt)
  );

  zt_sram_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
    .clk(clk), .rst_n(rst_n), .advance(advance), .flush(flush),
    .in_op(cmd_op), .in_addr(cmd_addr), .in_lanes(cmd_lanes),
    .s1_op(s1_op), .s1_addr(s1_addr),
    .s2_op(s2_op), .s2_addr(s2_addr), .s2_lanes(s2_lanes)
  );

  assign wr_en = advance && (s2_op == OP_WR);

  zt_sram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(s2_addr),
    .wr_lanes(s2_lanes), .wr_data(dq_in), .rd_addr(s1_addr), .rd_data(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      oe_q   <= 1'b0;
    end else if (flush) begin
      oe_q   <= 1'b0;
    end else if (advance) begin
      oe_q <= (s1_op == OP_RD);
      if (s1_op == OP_RD) dout_q <= rd_word;
    end
  end

  assign dq_out = dout_q;
  assign dq_oe  = oe_q & ~sleep;

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk
  import zt_sram_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              sleep,
  input logic              advance,
  input logic              chip_sel,
  input logic              burst_adv,
  input op_e               s1_op,
  input op_e               s2_op,
  input logic [1:0]        burst_cnt,
  input logic              oe_q,
  input logic              dq_oe,
  input logic [DATA_W-1:0] dq_out
);

  assert_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !burst_adv && !chip_sel) |=> (s1_op == OP_NOP));

  assert_read_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && s1_op == OP_RD) |=> oe_q);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !sleep) |=> ($stable(oe_q) && $stable(dq_out) && $stable(s1_op) && $stable(s2_op)));

  assert_burst_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && burst_adv) |=> (burst_cnt == $past(burst_cnt) + 2'd1));

  assert_bus_turn_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_op == OP_WR) |-> !dq_oe);

  assert_sleep_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dq_oe);

  assert_wake_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep) |-> !dq_oe);

endmodule

bind zt_sram zt_sram_chk #(.DATA_W(LANES*LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sleep(sleep),
  .advance(advance), .chip_sel(chip_sel), .burst_adv(burst_adv),
  .s1_op(s1_op), .s2_op(s2_op), .burst_cnt(burst_cnt),
  .oe_q(oe_q), .dq_oe(dq_oe), .dq_out(dq_out)
);

// File: tb/test_zt_sram.sv
`timescale 1ns/1ps
module test_zt_sram;
  localparam int AW = 6, LN = 2, LW = 9, DW = LN*LW, DEPTH = 1 << AW;
  localparam int NOP = 0, RD = 1, WR = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, clk_en, sleep, sel_a_n, sel_b, sel_c_n, wr_n, burst_adv, order_lin;
  logic [AW-1:0] addr;
  logic [LN-1:0] lane_wr_n;
  logic [DW-1:0] dq_in, dq_out;
  logic          dq_oe;

  zt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) i_zt_sram (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sleep(sleep),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .wr_n(wr_n),
    .burst_adv(burst_adv), .order_lin(order_lin), .addr(addr),
    .lane_wr_n(lane_wr_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int    n_tests = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done = 0;

  typedef struct {int op; int a; int ln;} ent_t;
  ent_t          pq[$];
  logic [DW-1:0] ref_mem [DEPTH];
  logic          exp_oe;
  logic [DW-1:0] exp_dout;
  int m_hi, m_base, m_cnt, m_bop;

  task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    ent_t e0 = '{NOP, 0, 0};
    ent_t o, m, e;
    int lo;
    if (sleep) begin
      pq = {e0, e0};
      exp_oe = 1'b0;
      m_bop = NOP;
      return;
    end
    if (!clk_en) return;
    o = pq[0];
    m = pq[1];
    if (o.op == WR)
      for (int l = 0; l < LN; l++)
        if (o.ln[l]) ref_mem[o.a][l*LW +: LW] = dq_in[l*LW +: LW];
    if (m.op == RD) begin
      exp_dout = ref_mem[m.a];
      exp_oe = 1'b1;
    end else exp_oe = 1'b0;
    e = e0;
    if (burst_adv) begin
      m_cnt = (m_cnt + 1) % 4;
      lo = order_lin ? (m_base + m_cnt) % 4 : (m_base ^ m_cnt);
      e.op = m_bop;
      e.a = m_hi * 4 + lo;
    end else begin
      if (!sel_a_n && sel_b && !sel_c_n) e.op = wr_n ? RD : WR;
      e.a = int'(addr);
      m_hi = int'(addr) / 4;
      m_base = int'(addr) % 4;
      m_cnt = 0;
      m_bop = e.op;
    end
    e.ln = (e.op == WR) ? int'(~lane_wr_n) : 0;
    void'(pq.pop_front());
    pq.push_back(e);
  endtask

  task automatic cyc(bit ce, bit an, bit b, bit cn, bit wn, bit adv,
                     logic [LN-1:0] lwn, bit lin, bit slp, logic [AW-1:0] ad);
    @(negedge clk);
    check(cur_req, "dq_oe", DW'(dq_oe), DW'(exp_oe & !sleep));
    if (exp_oe && !sleep) check(cur_req, "dq_out", dq_out, exp_dout);
    if (pq[0].op == WR) check("R10", "dq_oe in write slot", DW'(dq_oe), '0);
    clk_en = ce; sel_a_n = an; sel_b = b; sel_c_n = cn; wr_n = wn;
    burst_adv = adv; lane_wr_n = lwn; order_lin = lin; sleep = slp; addr = ad;
    dq_in = DW'({$urandom, $urandom});
    @(posedge clk);
    #1;
    model_edge();
  endtask

  task automatic wr(int a, logic [LN-1:0] lwn); cyc(1,0,1,0,0,0,lwn,1,0,AW'(a)); endtask
  task automatic rd(int a);                     cyc(1,0,1,0,1,0,'1,1,0,AW'(a)); endtask
  task automatic idle();                        cyc(1,1,1,0,1,0,'1,1,0,'0); endtask
  task automatic stall();                       cyc(0,0,1,0,0,0,'0,1,0,AW'(7)); endtask
  task automatic burst(bit lin, logic [LN-1:0] lwn); cyc(1,1,0,1,1,1,lwn,lin,0,'0); endtask
  task automatic snooze();                      cyc(1,1,0,1,0,0,'0,1,1,'0); endtask

  initial begin
    #1000000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    ent_t e0 = '{NOP, 0, 0};
    pq = {e0, e0};
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    exp_oe = 0; exp_dout = '0; m_hi = 0; m_base = 0; m_cnt = 0; m_bop = NOP;
    rst_n = 0; clk_en = 1; sleep = 0; sel_a_n = 1; sel_b = 0; sel_c_n = 1;
    wr_n = 1; burst_adv = 0; order_lin = 1; addr = '0; lane_wr_n = '1; dq_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state seen at the ports
    check("R1", "dq_oe after reset", DW'(dq_oe), '0);
    check("R1", "dq_out after reset", dq_out, '0);
    rst_n = 1;
    rd(5); idle(); idle(); idle();

    cur_req = "R4";
    for (int i = 0; i < 8; i++) wr(i, 2'b00);
    wr(8, 2'b10); wr(9, 2'b01);
    idle(); idle();
    cur_req = "R3";
    for (int i = 0; i < 10; i++) rd(i);
    idle(); idle(); idle();

    cur_req = "R5";
    for (int i = 0; i < 24; i++) begin
      if (i % 2 == 0) wr(i % 6 + 10, 2'b00); else rd(i % 6 + 10);
    end
    idle(); idle();

    cur_req = "R6";
    wr(20, 2'b00); rd(20); wr(20, 2'b10); rd(20); wr(20, 2'b01); rd(20);
    idle(); idle(); idle();

    cur_req = "R2";
    cyc(1,1,1,0,0,0,2'b00,1,0,AW'(30));
    cyc(1,0,0,0,0,0,2'b00,1,0,AW'(30));
    cyc(1,0,1,1,0,0,2'b00,1,0,AW'(30));
    cyc(1,1,0,1,1,0,2'b11,1,0,AW'(30));
    idle(); rd(30); idle(); idle(); idle();

    cur_req = "R7";
    wr(40, 2'b00); stall(); stall(); rd(40); stall(); idle(); stall(); stall(); idle(); idle(); idle();

    cur_req = "R8";
    wr(13, 2'b00); burst(1, 2'b00); burst(1, 2'b01); burst(1, 2'b00); burst(1, 2'b00);
    idle(); idle();
    rd(13); for (int i = 0; i < 5; i++) burst(1, '1);
    rd(13); for (int i = 0; i < 5; i++) burst(0, '1);
    wr(26, 2'b00); for (int i = 0; i < 3; i++) burst(0, 2'b00);
    idle(); burst(1, 2'b00); burst(1, 2'b00);
    rd(24); for (int i = 0; i < 3; i++) burst(1, '1);
    idle(); idle(); idle();

    cur_req = "R9";
    wr(50, 2'b11); burst(1, 2'b11); idle(); idle();
    rd(50); rd(51); idle(); idle(); idle();

    cur_req = "R11";
    rd(1); wr(2, 2'b00); snooze(); snooze(); snooze(); idle(); idle(); idle();
    rd(2); burst(1, '1); idle(); idle(); idle();

    cur_req = "R5";
    for (int i = 0; i < 300; i++) begin
      int k = $urandom_range(0, 9);
      int a = $urandom_range(0, 15);
      if (k < 4)       wr(a, LN'($urandom));
      else if (k < 8)  rd(a);
      else if (k == 8) stall();
      else             burst(1'($urandom), LN'($urandom));
    end
    idle(); idle(); idle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule